// File: doc/BRIEF.md
# Load-Use Stall Detector

This block lives in the decode stage of an in-order five-stage pipeline. It looks at the instruction that is now in execute. If that instruction reads memory and writes a register that the instruction being decoded names as an operand, the loaded value cannot be available in time, even with forwarding. The block then freezes instruction fetch and the fetch/decode register for one cycle. It also turns the instruction entering execute into a no-op by clearing every control field headed there.

The block is purely combinational and reacts to its inputs in the same cycle. On the next edge the no-op sits in execute and carries no memory-read flag, so the stall releases by itself. The consumer, still held in decode, then proceeds and receives the loaded value from the memory/writeback forwarding path.

Top module: `load_use_hazard`

## Requirements
- R1: When `ex_is_load` is 1 and `ex_load_dst` equals `dec_src_a` (a nonzero register), `stall` is 1 in the same cycle.
- R2: When `ex_is_load` is 1 and `ex_load_dst` equals `dec_src_b` (a nonzero register), `stall` is 1 in the same cycle.
- R3: When `ex_is_load` is 0, `stall` is 0 whatever the register numbers are, so a bubble or a non-load producer never stalls.
- R4: A load whose destination is register 0 never stalls, even if an operand field is also 0 (with `ZERO_EXEMPT`=1, the default).
- R5: `pc_write_en` and `dec_reg_write_en` are both 0 while `stall` is 1, and both 1 otherwise.
- R6: While `stall` is 1, every bit of `ex_ctrl_out` is 0. Otherwise `ex_ctrl_out` equals `dec_ctrl_in` bit for bit.
- R7: A load whose destination matches neither operand does not stall.
- R8: A match on both operands at once still gives a single stall. In a cycle-by-cycle pipeline sequence (load, then consumer), the stall lasts exactly one cycle: in the next cycle execute holds the bubble. A consumer two slots behind the load never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_is_load | input | 1 | Instruction in execute reads memory |
| ex_load_dst | input | REG_W | Destination register of the instruction in execute |
| dec_src_a | input | REG_W | First source register field of the decoding instruction |
| dec_src_b | input | REG_W | Second source register field of the decoding instruction |
| dec_ctrl_in | input | CTRL_W | Control fields decoded for the instruction entering execute |
| pc_write_en | output | 1 | Program counter may update |
| dec_reg_write_en | output | 1 | Fetch/decode pipeline register may load |
| stall | output | 1 | Load-use hazard detected this cycle |
| ex_ctrl_out | output | CTRL_W | Control fields passed to execute, cleared during a stall |

## Verification
Two detections can coincide in one cycle. Both operand comparisons can hit together, and a comparison can hit on register 0 while the load flag is set. The bench provokes the first by giving the consumer the same register in both operand fields. It provokes the second by loading into register 0 while an operand also names 0. It then judges that the first case gives one ordinary stall, with frozen enables and cleared controls, and that the second case passes everything through untouched. The pipeline sequences step a load, a bubble and later producers through execute while the consumer is held in decode, to confirm that the stall lasts exactly one cycle.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_SRC_A = 2'b01,
    CAUSE_SRC_B = 2'b10,
    CAUSE_BOTH  = 2'b11
  } hazard_cause_e;

  // Combine per-operand hits into a cause code.
  function automatic hazard_cause_e cause_of(input logic hit_a, input logic hit_b);
    hazard_cause_e c;
    unique case ({hit_b, hit_a})
      2'b00:   c = CAUSE_NONE;
      2'b01:   c = CAUSE_SRC_A;
      2'b10:   c = CAUSE_SRC_B;
      default: c = CAUSE_BOTH;
    endcase
    return c;
  endfunction

  // A cause other than none means some operand depends on the load.
  function automatic logic cause_blocks(input hazard_cause_e c);
    return c != CAUSE_NONE;
  endfunction

endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int REG_W       = 5,
  parameter bit ZERO_EXEMPT = 1'b1
) (
  input  logic [REG_W-1:0] load_dst,
  input  logic [REG_W-1:0] src_reg,
  output logic             hit
);

  logic same;
  assign same = (load_dst == src_reg);

  generate
    if (ZERO_EXEMPT) begin : g_exempt
      logic dst_nonzero;
      assign dst_nonzero = |load_dst;
      assign hit = same && dst_nonzero;
    end else begin : g_plain
      assign hit = same;
    end
  endgenerate

endmodule

// File: rtl/lu_ctrl_squash.sv
module lu_ctrl_squash #(
  parameter int CTRL_W = 9
) (
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              squash,
  output logic [CTRL_W-1:0] ctrl_out
);

  genvar i;
  generate
    for (i = 0; i < CTRL_W; i++) begin : g_bit
      assign ctrl_out[i] = ctrl_in[i] & ~squash;
    end
  endgenerate

endmodule

// File: rtl/load_use_hazard.sv
module load_use_hazard
  import lu_hazard_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int CTRL_W      = 9,
  parameter bit ZERO_EXEMPT = 1'b1
) (
  input  logic              ex_is_load,
  input  logic [REG_W-1:0]  ex_load_dst,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic [CTRL_W-1:0] dec_ctrl_in,
  output logic              pc_write_en,
  output logic              dec_reg_write_en,
  output logic              stall,
  output logic [CTRL_W-1:0] ex_ctrl_out
);

  localparam int NUM_SRC = 2;

  logic [REG_W-1:0]   src_vec [NUM_SRC];
  logic [NUM_SRC-1:0] src_hit;
  hazard_cause_e      cause;
  logic               load_blocks;

  assign src_vec[0] = dec_src_a;
  assign src_vec[1] = dec_src_b;

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_src
      lu_src_match #(
        .REG_W      (REG_W),
        .ZERO_EXEMPT(ZERO_EXEMPT)
      ) u_match (
        .load_dst(ex_load_dst),
        .src_reg (src_vec[s]),
        .hit     (src_hit[s])
      );
    end
  endgenerate

  assign cause       = cause_of(src_hit[0], src_hit[1]);
  assign load_blocks = ex_is_load && cause_blocks(cause);

  assign stall            = load_blocks;
  assign pc_write_en      = ~load_blocks;
  assign dec_reg_write_en = ~load_blocks;

  lu_ctrl_squash #(
    .CTRL_W(CTRL_W)
  ) u_squash (
    .ctrl_in (dec_ctrl_in),
    .squash  (load_blocks),
    .ctrl_out(ex_ctrl_out)
  );

endmodule

// File: rtl/load_use_hazard_chk.sv
module load_use_hazard_chk #(
  parameter int REG_W       = 5,
  parameter int CTRL_W      = 9,
  parameter bit ZERO_EXEMPT = 1'b1
) (
  input logic              ex_is_load,
  input logic [REG_W-1:0]  ex_load_dst,
  input logic [REG_W-1:0]  dec_src_a,
  input logic [REG_W-1:0]  dec_src_b,
  input logic [CTRL_W-1:0] dec_ctrl_in,
  input logic              pc_write_en,
  input logic              dec_reg_write_en,
  input logic              stall,
  input logic [CTRL_W-1:0] ex_ctrl_out
);

  logic dst_live;
  assign dst_live = (ex_load_dst != '0) || !ZERO_EXEMPT;

  always_comb begin
    // R1
    src_a_stall_chk: assert (!(ex_is_load && dst_live && ex_load_dst == dec_src_a) || stall);
    // R2
    src_b_stall_chk: assert (!(ex_is_load && dst_live && ex_load_dst == dec_src_b) || stall);
    // R3
    no_load_no_stall_chk: assert (ex_is_load || !stall);
    // R4
    zero_dst_chk: assert (dst_live || !stall);
    // R5
    freeze_chk: assert ((pc_write_en == !stall) && (dec_reg_write_en == !stall));
    // R6
    bubble_chk: assert (stall ? (ex_ctrl_out == '0) : (ex_ctrl_out == dec_ctrl_in));
    // R7
    unrelated_chk: assert (!stall || ex_load_dst == dec_src_a || ex_load_dst == dec_src_b);
  end

endmodule

bind load_use_hazard load_use_hazard_chk #(
  .REG_W      (REG_W),
  .CTRL_W     (CTRL_W),
  .ZERO_EXEMPT(ZERO_EXEMPT)
) u_chk (.*);

// File: tb/load_use_hazard_bench.sv
module load_use_hazard_bench;

  localparam int REG_W  = 5;
  localparam int CTRL_W = 9;
  localparam logic [CTRL_W-1:0] CTRL_PAT = 9'h1A5;

  logic              clk = 1'b0;
  logic              ex_is_load;
  logic [REG_W-1:0]  ex_load_dst;
  logic [REG_W-1:0]  dec_src_a;
  logic [REG_W-1:0]  dec_src_b;
  logic [CTRL_W-1:0] dec_ctrl_in;
  logic              pc_write_en;
  logic              dec_reg_write_en;
  logic              stall;
  logic [CTRL_W-1:0] ex_ctrl_out;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  load_use_hazard u_load_use_hazard (
    .ex_is_load      (ex_is_load),
    .ex_load_dst     (ex_load_dst),
    .dec_src_a       (dec_src_a),
    .dec_src_b       (dec_src_b),
    .dec_ctrl_in     (dec_ctrl_in),
    .pc_write_en     (pc_write_en),
    .dec_reg_write_en(dec_reg_write_en),
    .stall           (stall),
    .ex_ctrl_out     (ex_ctrl_out)
  );

  // Drive one cycle's inputs at the falling edge; sample shortly after.
  task automatic apply(input logic ld, input logic [REG_W-1:0] dst,
                       input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                       input logic [CTRL_W-1:0] ctl);
    @(negedge clk);
    ex_is_load  = ld;
    ex_load_dst = dst;
    dec_src_a   = a;
    dec_src_b   = b;
    dec_ctrl_in = ctl;
    #1;
  endtask

  // Full check of every output against the expected stall decision.
  task automatic expect_outputs(input string req, input logic exp_stall,
                                input logic [CTRL_W-1:0] ctl);
    logic [CTRL_W-1:0] exp_ctrl;
    exp_ctrl = exp_stall ? '0 : ctl;
    tests++;
    if (stall !== exp_stall) begin
      fails++;
      $display("FAIL %s stall actual=%b expected=%b", req, stall, exp_stall);
    end
    tests++;
    if (pc_write_en !== !exp_stall || dec_reg_write_en !== !exp_stall) begin
      fails++;
      $display("FAIL R5 (%s) enables actual=%b%b expected=%b%b", req,
               pc_write_en, dec_reg_write_en, !exp_stall, !exp_stall);
    end
    tests++;
    if (ex_ctrl_out !== exp_ctrl) begin
      fails++;
      $display("FAIL R6 (%s) ctrl actual=%h expected=%h", req, ex_ctrl_out, exp_ctrl);
    end
  endtask

  task automatic t_reset_state;
    apply(1'b0, '0, '0, '0, '0);
    expect_outputs("R3 idle", 1'b0, '0);
  endtask

  task automatic t_src_a;  // R1
    apply(1'b1, 5'd2, 5'd2, 5'd5, CTRL_PAT);
    expect_outputs("R1", 1'b1, CTRL_PAT);
    apply(1'b1, 5'd31, 5'd31, 5'd0, 9'h1FF);
    expect_outputs("R1 top reg", 1'b1, 9'h1FF);
  endtask

  task automatic t_src_b;  // R2
    apply(1'b1, 5'd7, 5'd4, 5'd7, CTRL_PAT);
    expect_outputs("R2", 1'b1, CTRL_PAT);
  endtask

  task automatic t_not_load;  // R3
    apply(1'b0, 5'd9, 5'd9, 5'd9, CTRL_PAT);
    expect_outputs("R3", 1'b0, CTRL_PAT);
  endtask

  task automatic t_zero_dst;  // R4
    apply(1'b1, 5'd0, 5'd0, 5'd0, CTRL_PAT);
    expect_outputs("R4", 1'b0, CTRL_PAT);
    apply(1'b1, 5'd0, 5'd0, 5'd3, 9'h0FF);
    expect_outputs("R4 one operand", 1'b0, 9'h0FF);
  endtask

  task automatic t_unrelated;  // R7
    apply(1'b1, 5'd12, 5'd13, 5'd11, CTRL_PAT);
    expect_outputs("R7", 1'b1 & 1'b0, CTRL_PAT);
    apply(1'b1, 5'd16, 5'd0, 5'd17, 9'h155);
    expect_outputs("R7 near", 1'b0, 9'h155);
  endtask

  task automatic t_both_and_sequence;  // R8
    // Both operands depend on the load.
    apply(1'b1, 5'd6, 5'd6, 5'd6, CTRL_PAT);
    expect_outputs("R8 both", 1'b1, CTRL_PAT);
    // Next cycle: bubble (no memory read, zero controls) now in execute,
    // consumer still held in decode.
    apply(1'b0, 5'd0, 5'd6, 5'd6, CTRL_PAT);
    expect_outputs("R8 released", 1'b0, CTRL_PAT);
    // Load, one unrelated instruction, then a dependent instruction:
    // when the dependent decodes, execute holds the unrelated ALU op.
    apply(1'b1, 5'd8, 5'd1, 5'd3, CTRL_PAT);
    expect_outputs("R8 gap slot", 1'b0, CTRL_PAT);
    apply(1'b0, 5'd10, 5'd8, 5'd8, 9'h0F0);
    expect_outputs("R8 two behind", 1'b0, 9'h0F0);
  endtask

  initial begin
    ex_is_load  = 1'b0;
    ex_load_dst = '0;
    dec_src_a   = '0;
    dec_src_b   = '0;
    dec_ctrl_in = '0;
    t_reset_state();
    t_src_a();
    t_src_b();
    t_not_load();
    t_zero_dst();
    t_unrelated();
    t_both_and_sequence();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule